// File: doc/BRIEF.md
# Token-Counting Coherence Permission Controller

This block guards one cache line in a multiprocessor whose coherence safety comes from counting tokens rather than from the order in which requests cross the network. Every line has a fixed system-wide total of tokens (16 by default). A cache may read the line when it holds at least one token together with valid data, and may write it only when it holds every token. The controller keeps the local token count, an owner flag (one token is the owner token, and its holder is the party that supplies data) and a data-valid flag. It grants or refuses local loads and stores from those three values alone.

Requests from other caches arrive over an unordered broadcast network and carry the requester's id and whether it wants to read or write. The controller answers them by sending tokens, with or without data, on its outgoing response port. Token responses from other caches or from memory arrive on the incoming response port and are added to the local count. A replacement of the line is never silent: its tokens are sent back toward memory. A request that finds the line with no tokens gets no answer at all; recovering from that is the job of the requester's retry logic, which lies outside this block.

Top module: `tokline_ctrl`

## Requirements
- R1: After reset the line holds zero tokens, owner flag 0, data-valid 0, and no outgoing response is valid.
- R2: A local read (`acc_write`=0) is granted in the same cycle if and only if the line holds at least one token and its data is valid.
- R3: A local write (`acc_write`=1) is granted in the same cycle if and only if the line holds all TOK_TOTAL (16) tokens.
- R4: An incoming response adds its token count to the local count at the next clock edge; its owner bit sets the owner flag and its data bit sets data-valid. The count never exceeds TOK_TOTAL and the owner flag is never set with zero tokens.
- R5: A read request that finds the line holding the owner token is answered one cycle later, addressed to the requester, with exactly one token and the data bit set; the local count drops by one (16 becomes 15). The owner bit travels only when that was the last token held.
- R6: A read request that finds the line holding tokens but not the owner token is ignored: no response, count unchanged.
- R7: A write request that finds the line holding tokens is answered one cycle later with every token held, the owner bit equal to the former owner flag and the data bit set only if the line was owner with valid data; the line then holds zero tokens, no owner flag and invalid data.
- R8: Any request or replacement that finds the line holding zero tokens produces no response.
- R9: A replacement (`evict`) with tokens held sends all of them one cycle later with `rsp_out_to_mem`=1, owner and data bits as in R7. When a request arrives in the same cycle, the request is served and the replacement has no effect in that cycle.
- R10: When tokens are sent and received in the same cycle, the new count is the held count minus the tokens sent plus the tokens received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Local access request |
| acc_write | input | 1 | Local access is a write (1) or read (0) |
| acc_grant | output | 1 | Local access permitted this cycle |
| req_valid | input | 1 | Incoming request from another cache |
| req_id | input | ID_W | Id of the requesting cache |
| req_write | input | 1 | Incoming request wants to write (1) or read (0) |
| rsp_in_valid | input | 1 | Incoming token response |
| rsp_in_tokens | input | CNT_W | Number of tokens arriving |
| rsp_in_owner | input | 1 | Arriving tokens include the owner token |
| rsp_in_data | input | 1 | Arriving response carries data |
| evict | input | 1 | Replace the line, returning its tokens |
| rsp_out_valid | output | 1 | Outgoing response valid |
| rsp_out_dest | output | ID_W | Destination cache id (meaningless when to memory) |
| rsp_out_to_mem | output | 1 | Outgoing response goes to memory |
| rsp_out_tokens | output | CNT_W | Number of tokens sent |
| rsp_out_owner | output | 1 | Owner token is among those sent |
| rsp_out_data | output | 1 | Response carries data |
| tok_count | output | CNT_W | Tokens currently held |
| line_owner | output | 1 | Owner token currently held |
| line_valid | output | 1 | Data currently valid |

## Verification
Grants are combinational from the held state, so the bench sets the access inputs between edges and reads `acc_grant` a moment later without a clock. Every other result (new count, owner and valid flags, the outgoing response) is due at the first rising edge after the stimulus is presented, so each task drives its inputs 2 ns after an edge, waits one edge, clears the inputs and checks 2 ns later. The outgoing response lasts a single cycle, which the bench confirms by checking it is gone after one idle edge.

// File: rtl/tokline_pkg.sv
// Shared types for the token-counting line controller.
// Assumes nothing beyond IEEE 1800-2017.
package tokline_pkg;

    // What the line does with the request or replacement seen this cycle.
    typedef enum logic [1:0] {
        ACT_NONE      = 2'd0,   // nothing to send
        ACT_SHARE     = 2'd1,   // owner hands one token plus data to a reader
        ACT_SURRENDER = 2'd2,   // every token goes to a writer
        ACT_WRITEBACK = 2'd3    // every token goes back to memory
    } tok_act_e;

endpackage

// File: rtl/tokline_perm.sv
// Local permission check: decides whether a load or store may proceed.
// Assumes tok_q, valid_q come from registered line state.
module tokline_perm #(
    parameter int TOK_TOTAL = 16,
    parameter int CNT_W     = $clog2(TOK_TOTAL + 1)
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [CNT_W-1:0] tok_q,
    input  logic             valid_q,
    output logic             acc_grant
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TOK_TOTAL);

    logic may_read;
    logic may_write;

    // Read needs one token and data; write needs every token.
    always_comb begin
        may_read  = (tok_q != '0) && valid_q;
        may_write = (tok_q == FULL);
        acc_grant = acc_valid && (acc_write ? may_write : may_read);
    end

endmodule

// File: rtl/tokline_resp.sv
// Response selector: chooses how the line answers a request or replacement.
// Assumes at most one request per cycle; a request outranks a replacement.
module tokline_resp
    import tokline_pkg::*;
#(
    parameter int TOK_TOTAL = 16,
    parameter int CNT_W     = $clog2(TOK_TOTAL + 1),
    parameter int ID_W      = 4
) (
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_id,
    input  logic             req_write,
    input  logic             evict,
    input  logic [CNT_W-1:0] tok_q,
    input  logic             owner_q,
    input  logic             valid_q,
    output tok_act_e         act,
    output logic [CNT_W-1:0] send_tok,
    output logic             send_owner,
    output logic             send_data,
    output logic             send_mem,
    output logic [ID_W-1:0]  send_dest
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic holds_any;

    // Classify the incoming event against the held tokens.
    always_comb begin
        holds_any = (tok_q != '0);
        act       = ACT_NONE;
        if (req_valid && holds_any) begin
            if (req_write)    act = ACT_SURRENDER;
            else if (owner_q) act = ACT_SHARE;
        end else if (!req_valid && evict && holds_any) begin
            act = ACT_WRITEBACK;
        end
    end

    // Build the outgoing token bundle for the chosen action.
    always_comb begin
        send_tok   = '0;
        send_owner = 1'b0;
        send_data  = 1'b0;
        send_mem   = 1'b0;
        send_dest  = req_id;
        case (act)
            ACT_SHARE: begin
                send_tok   = ONE;
                send_owner = (tok_q == ONE);
                send_data  = valid_q;
            end
            ACT_SURRENDER: begin
                send_tok   = tok_q;
                send_owner = owner_q;
                send_data  = owner_q && valid_q;
            end
            ACT_WRITEBACK: begin
                send_tok   = tok_q;
                send_owner = owner_q;
                send_data  = owner_q && valid_q;
                send_mem   = 1'b1;
                send_dest  = '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tokline_state.sv
// Line state and outgoing response register.
// Holds token count, owner flag and data-valid flag; registers the response.
// Assumes incoming owner tokens always arrive with at least one token.
module tokline_state
    import tokline_pkg::*;
#(
    parameter int TOK_TOTAL = 16,
    parameter int CNT_W     = $clog2(TOK_TOTAL + 1),
    parameter int ID_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tok_act_e         act,
    input  logic [CNT_W-1:0] send_tok,
    input  logic             send_owner,
    input  logic             send_data,
    input  logic             send_mem,
    input  logic [ID_W-1:0]  send_dest,
    input  logic             rsp_in_valid,
    input  logic [CNT_W-1:0] rsp_in_tokens,
    input  logic             rsp_in_owner,
    input  logic             rsp_in_data,
    output logic [CNT_W-1:0] tok_q,
    output logic             owner_q,
    output logic             valid_q,
    output logic             rsp_out_valid,
    output logic [ID_W-1:0]  rsp_out_dest,
    output logic             rsp_out_to_mem,
    output logic [CNT_W-1:0] rsp_out_tokens,
    output logic             rsp_out_owner,
    output logic             rsp_out_data
);
    localparam int          SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(TOK_TOTAL);

    logic             fire;
    logic [CNT_W-1:0] kept;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] tok_d;
    logic             owner_d;
    logic             valid_d;

    // Next line state: keep what was not sent, then add what arrived.
    always_comb begin
        fire    = (act != ACT_NONE);
        kept    = fire ? (tok_q - send_tok) : tok_q;
        sum     = {1'b0, kept} + (rsp_in_valid ? {1'b0, rsp_in_tokens} : '0);
        tok_d   = sum[CNT_W-1:0];
        owner_d = (owner_q && !(fire && send_owner)) || (rsp_in_valid && rsp_in_owner);
        valid_d = ((kept != '0) && valid_q) || (rsp_in_valid && rsp_in_data);
    end

    // Line state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q   <= '0;
            owner_q <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            tok_q   <= tok_d;
            owner_q <= owner_d;
            valid_q <= valid_d;
        end
    end

    // Outgoing response register, valid for one cycle per action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_out_valid  <= 1'b0;
            rsp_out_dest   <= '0;
            rsp_out_to_mem <= 1'b0;
            rsp_out_tokens <= '0;
            rsp_out_owner  <= 1'b0;
            rsp_out_data   <= 1'b0;
        end else begin
            rsp_out_valid  <= fire;
            rsp_out_dest   <= send_dest;
            rsp_out_to_mem <= send_mem;
            rsp_out_tokens <= fire ? send_tok : '0;
            rsp_out_owner  <= fire && send_owner;
            rsp_out_data   <= fire && send_data;
        end
    end

    // R4: the arriving sum may never pass the system-wide total
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum <= LIMIT);

    // R4: owner flag never stands with zero tokens
    owner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner_q |-> (tok_q != '0));

    // R10: count after an exchange is held minus sent plus received
    balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !rsp_in_valid) |=> (tok_q == $past(tok_q) - rsp_out_tokens));

endmodule

// File: rtl/tokline_ctrl.sv
// Token-counting coherence permission controller for one cache line.
// Grants local access from the held token count and answers remote
// requests with tokens; assumes the network and memory conserve tokens.
module tokline_ctrl
    import tokline_pkg::*;
#(
    parameter int TOK_TOTAL = 16,
    parameter int ID_W      = 4,
    parameter int CNT_W     = $clog2(TOK_TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    output logic             acc_grant,
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_id,
    input  logic             req_write,
    input  logic             rsp_in_valid,
    input  logic [CNT_W-1:0] rsp_in_tokens,
    input  logic             rsp_in_owner,
    input  logic             rsp_in_data,
    input  logic             evict,
    output logic             rsp_out_valid,
    output logic [ID_W-1:0]  rsp_out_dest,
    output logic             rsp_out_to_mem,
    output logic [CNT_W-1:0] rsp_out_tokens,
    output logic             rsp_out_owner,
    output logic             rsp_out_data,
    output logic [CNT_W-1:0] tok_count,
    output logic             line_owner,
    output logic             line_valid
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TOK_TOTAL);

    tok_act_e         act;
    logic [CNT_W-1:0] send_tok;
    logic             send_owner;
    logic             send_data;
    logic             send_mem;
    logic [ID_W-1:0]  send_dest;
    logic [CNT_W-1:0] tok_q;
    logic             owner_q;
    logic             valid_q;

    tokline_perm #(.TOK_TOTAL(TOK_TOTAL), .CNT_W(CNT_W)) u_perm (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .tok_q     (tok_q),
        .valid_q   (valid_q),
        .acc_grant (acc_grant)
    );

    tokline_resp #(.TOK_TOTAL(TOK_TOTAL), .CNT_W(CNT_W), .ID_W(ID_W)) u_resp (
        .req_valid  (req_valid),
        .req_id     (req_id),
        .req_write  (req_write),
        .evict      (evict),
        .tok_q      (tok_q),
        .owner_q    (owner_q),
        .valid_q    (valid_q),
        .act        (act),
        .send_tok   (send_tok),
        .send_owner (send_owner),
        .send_data  (send_data),
        .send_mem   (send_mem),
        .send_dest  (send_dest)
    );

    tokline_state #(.TOK_TOTAL(TOK_TOTAL), .CNT_W(CNT_W), .ID_W(ID_W)) u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .act            (act),
        .send_tok       (send_tok),
        .send_owner     (send_owner),
        .send_data      (send_data),
        .send_mem       (send_mem),
        .send_dest      (send_dest),
        .rsp_in_valid   (rsp_in_valid),
        .rsp_in_tokens  (rsp_in_tokens),
        .rsp_in_owner   (rsp_in_owner),
        .rsp_in_data    (rsp_in_data),
        .tok_q          (tok_q),
        .owner_q        (owner_q),
        .valid_q        (valid_q),
        .rsp_out_valid  (rsp_out_valid),
        .rsp_out_dest   (rsp_out_dest),
        .rsp_out_to_mem (rsp_out_to_mem),
        .rsp_out_tokens (rsp_out_tokens),
        .rsp_out_owner  (rsp_out_owner),
        .rsp_out_data   (rsp_out_data)
    );

    // Expose held state.
    always_comb begin
        tok_count  = tok_q;
        line_owner = owner_q;
        line_valid = valid_q;
    end

    // R3: a granted write always sees the full token set
    write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_grant && acc_write) |-> (tok_q == FULL));

    // R2: a granted read always sees a token and valid data
    read_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_grant && !acc_write) |-> ((tok_q != '0) && valid_q));

    // R8: nothing is sent for an event that finds no tokens
    zero_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_valid || evict) && (tok_q == '0)) |=> !rsp_out_valid);

    // R7: a write request leaves the line empty when nothing arrives
    write_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (tok_q != '0) && !rsp_in_valid)
            |=> (rsp_out_valid && (tok_q == '0) && !owner_q));

    // R5: every sent response carries at least one token
    nonempty_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_out_valid |-> (rsp_out_tokens != '0));

endmodule

// File: tb/tokline_ctrl_test.sv
// Directed bench for tokline_ctrl: one task per scenario.
module tokline_ctrl_test;
    localparam int TOK_TOTAL = 16;
    localparam int ID_W      = 4;
    localparam int CNT_W     = $clog2(TOK_TOTAL + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             acc_valid, acc_write, acc_grant;
    logic             req_valid, req_write;
    logic [ID_W-1:0]  req_id;
    logic             rsp_in_valid, rsp_in_owner, rsp_in_data;
    logic [CNT_W-1:0] rsp_in_tokens;
    logic             evict;
    logic             rsp_out_valid, rsp_out_to_mem, rsp_out_owner, rsp_out_data;
    logic [ID_W-1:0]  rsp_out_dest;
    logic [CNT_W-1:0] rsp_out_tokens, tok_count;
    logic             line_owner, line_valid;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tokline_ctrl #(.TOK_TOTAL(TOK_TOTAL), .ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_grant(acc_grant),
        .req_valid(req_valid), .req_id(req_id), .req_write(req_write),
        .rsp_in_valid(rsp_in_valid), .rsp_in_tokens(rsp_in_tokens),
        .rsp_in_owner(rsp_in_owner), .rsp_in_data(rsp_in_data),
        .evict(evict),
        .rsp_out_valid(rsp_out_valid), .rsp_out_dest(rsp_out_dest),
        .rsp_out_to_mem(rsp_out_to_mem), .rsp_out_tokens(rsp_out_tokens),
        .rsp_out_owner(rsp_out_owner), .rsp_out_data(rsp_out_data),
        .tok_count(tok_count), .line_owner(line_owner), .line_valid(line_valid)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic idle_inputs();
        acc_valid = 0; acc_write = 0;
        req_valid = 0; req_write = 0; req_id = '0;
        rsp_in_valid = 0; rsp_in_tokens = '0; rsp_in_owner = 0; rsp_in_data = 0;
        evict = 0;
    endtask

    // One edge, then inputs cleared and outputs settled 2 ns later.
    task automatic step();
        @(posedge clk);
        #2;
        idle_inputs();
    endtask

    task automatic fill(input int n, input bit own, input bit dat);
        rsp_in_valid = 1; rsp_in_tokens = CNT_W'(n);
        rsp_in_owner = own; rsp_in_data = dat;
        step();
    endtask

    task automatic grant_of(input bit wr, output bit g);
        acc_valid = 1; acc_write = wr;
        #1 g = acc_grant;
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic send_req(input int id, input bit wr);
        req_valid = 1; req_id = ID_W'(id); req_write = wr;
        step();
    endtask

    task automatic t_reset();
        bit g;
        chk("R1 tokens", tok_count, 0);
        chk("R1 owner", line_owner, 0);
        chk("R1 valid", line_valid, 0);
        chk("R1 rsp valid", rsp_out_valid, 0);
        grant_of(0, g); chk("R2 read at reset", g, 0);
    endtask

    task automatic t_full_and_share();
        bit g;
        fill(16, 1, 1);
        chk("R4 fill count", tok_count, 16);
        chk("R4 owner set", line_owner, 1);
        chk("R4 valid set", line_valid, 1);
        grant_of(1, g); chk("R3 write at 16", g, 1);
        grant_of(0, g); chk("R2 read at 16", g, 1);
        send_req(5, 0);
        chk("R5 rsp valid", rsp_out_valid, 1);
        chk("R5 dest", rsp_out_dest, 5);
        chk("R5 tokens", rsp_out_tokens, 1);
        chk("R5 owner kept", rsp_out_owner, 0);
        chk("R5 data", rsp_out_data, 1);
        chk("R5 to_mem", rsp_out_to_mem, 0);
        chk("R5 count 15", tok_count, 15);
        grant_of(1, g); chk("R3 write at 15", g, 0);
        grant_of(0, g); chk("R2 read at 15", g, 1);
        step();
        chk("R5 rsp one cycle", rsp_out_valid, 0);
    endtask

    task automatic t_write_steal();
        bit g;
        send_req(9, 1);
        chk("R7 rsp valid", rsp_out_valid, 1);
        chk("R7 dest", rsp_out_dest, 9);
        chk("R7 tokens", rsp_out_tokens, 15);
        chk("R7 owner", rsp_out_owner, 1);
        chk("R7 data", rsp_out_data, 1);
        chk("R7 count", tok_count, 0);
        chk("R7 owner cleared", line_owner, 0);
        chk("R7 valid cleared", line_valid, 0);
        grant_of(0, g); chk("R2 read at 0", g, 0);
    endtask

    task automatic t_zero_ignored();
        send_req(3, 1);
        chk("R8 write req at 0", rsp_out_valid, 0);
        send_req(3, 0);
        chk("R8 read req at 0", rsp_out_valid, 0);
        evict = 1; step();
        chk("R8 evict at 0", rsp_out_valid, 0);
        chk("R8 count stays 0", tok_count, 0);
    endtask

    task automatic t_non_owner();
        bit g;
        fill(3, 0, 1);
        grant_of(0, g); chk("R2 read non-owner", g, 1);
        send_req(2, 0);
        chk("R6 no rsp", rsp_out_valid, 0);
        chk("R6 count kept", tok_count, 3);
        send_req(4, 1);
        chk("R7 non-owner tokens", rsp_out_tokens, 3);
        chk("R7 non-owner owner bit", rsp_out_owner, 0);
        chk("R7 non-owner no data", rsp_out_data, 0);
        chk("R7 non-owner count", tok_count, 0);
    endtask

    task automatic t_no_data();
        bit g;
        fill(2, 0, 0);
        grant_of(0, g); chk("R2 tokens without data", g, 0);
        send_req(1, 1);
        chk("R7 drain tokens", rsp_out_tokens, 2);
    endtask

    task automatic t_evict();
        fill(2, 1, 1);
        evict = 1; step();
        chk("R9 evict valid", rsp_out_valid, 1);
        chk("R9 to_mem", rsp_out_to_mem, 1);
        chk("R9 tokens", rsp_out_tokens, 2);
        chk("R9 owner", rsp_out_owner, 1);
        chk("R9 data", rsp_out_data, 1);
        chk("R9 count", tok_count, 0);
        chk("R9 valid cleared", line_valid, 0);
    endtask

    task automatic t_last_token();
        fill(1, 1, 1);
        send_req(6, 0);
        chk("R5 last dest", rsp_out_dest, 6);
        chk("R5 last tokens", rsp_out_tokens, 1);
        chk("R5 last owner", rsp_out_owner, 1);
        chk("R5 last data", rsp_out_data, 1);
        chk("R5 last count", tok_count, 0);
        chk("R5 last owner gone", line_owner, 0);
    endtask

    task automatic t_collision();
        fill(4, 1, 1);
        req_valid = 1; req_id = 4'd1; req_write = 1;
        rsp_in_valid = 1; rsp_in_tokens = CNT_W'(3); rsp_in_owner = 0; rsp_in_data = 0;
        step();
        chk("R10 sent tokens", rsp_out_tokens, 4);
        chk("R10 sent owner", rsp_out_owner, 1);
        chk("R10 count", tok_count, 3);
        chk("R10 owner", line_owner, 0);
        chk("R10 valid", line_valid, 0);
        send_req(1, 1);
        chk("R10 drain", rsp_out_tokens, 3);
    endtask

    task automatic t_evict_vs_req();
        fill(5, 1, 1);
        evict = 1;
        req_valid = 1; req_id = 4'd7; req_write = 0;
        step();
        chk("R9 request wins dest", rsp_out_dest, 7);
        chk("R9 request wins to_mem", rsp_out_to_mem, 0);
        chk("R9 request wins tokens", rsp_out_tokens, 1);
        chk("R9 request wins count", tok_count, 4);
        evict = 1; step();
        chk("R9 later evict to_mem", rsp_out_to_mem, 1);
        chk("R9 later evict tokens", rsp_out_tokens, 4);
        chk("R9 later evict count", tok_count, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        t_reset();
        t_full_and_share();
        t_write_steal();
        t_zero_ignored();
        t_non_owner();
        t_no_data();
        t_evict();
        t_last_token();
        t_collision();
        t_evict_vs_req();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule